// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This engine drains outgoing frames from a circular ring of transmit descriptors that host software prepares in shared memory. A scan pass begins on a transmit-demand pulse or a periodic poll pulse. Each frame attempt starts at the current ring position. The engine first walks the descriptor chain and reads only the status words. This confirms that every descriptor up to end of packet belongs to the controller, and it gives the frame length. The engine then walks the chain a second time. It fetches each buffer through a 32-bit memory port and streams the bytes out on a valid/ready byte interface, with a last flag on the final byte.

Descriptors without the start-of-packet flag go back to the host as soon as their buffer has been read. The first descriptor goes back only after the whole frame has been sent, and a one-cycle transmit interrupt then marks the frame as complete. If a chained descriptor is still held by the host, the engine signals underflow and abandons the attempt without writing anything. The ring position stays where it was, so a later pass retries the same frame. One pass sends a bounded number of frames. It also ends at the first attempt that cannot proceed.

The ring size is 2 to the power of the size input, limited to 512 entries. Frame check sequence generation and the physical interface are handled elsewhere.

Top module: `tx_ring_gather`

## Requirements
- R1: Descriptor i occupies 16 bytes at ring base + 16*i, and its status word is at offset 4. Status bits: 31 = owned by controller, 25 = start of packet, 24 = end of packet, and bits 11:0 = buffer length written as its 12-bit two's-complement negative. With style_i = 0 the buffer address word is at offset 0; with style_i = 1 it is at offset 8. A memory request holds its address until acknowledged.
- R2: An attempt does nothing (no memory write, no byte, no interrupt) when the ring base is zero, tx_on_i is low, out_ready_i is low at the attempt, or the first descriptor is not owned. In each case the descriptor stays owned for a later pass.
- R3: Frame bytes leave in ascending buffer address order, with address a taken from bits 8*(a mod 4) of its aligned word. Buffers may start unaligned. out_last_o marks only the final byte of a frame. Under backpressure the data and last flag hold steady.
- R4: Every descriptor whose start-of-packet bit is clear gets its status rewritten with bit 31 cleared and all other bits kept, after its buffer has been read.
- R5: After a complete frame the first descriptor's status is rewritten with bit 31 cleared, and tx_int_o pulses for exactly one cycle per frame.
- R6: When a chained descriptor is not owned, underflow_o pulses for one cycle. No byte is sent, nothing is written, no interrupt occurs, and the ring position is kept.
- R7: The ring position advances by one for each consumed descriptor and wraps to 0 at 2^ring_log2_i entries. A frame may chain across the wrap.
- R8: A pass starts on demand_i or poll_i while idle and sends at most 16 frames.
- R9: A frame is cut to 2048 bytes. The last flag sits on byte 2048, and all descriptors of the frame are still released.
- R10: A frame whose buffers total zero bytes sends no byte, but its descriptors are still released and tx_int_o still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_base_i | input | 32 | Byte address of descriptor 0 |
| ring_log2_i | input | 4 | Ring size as a power of two (limited to 9) |
| style_i | input | 1 | Descriptor layout: 0 = buffer address at offset 0, 1 = at offset 8 |
| tx_on_i | input | 1 | Transmitter enabled |
| demand_i | input | 1 | Transmit-demand pulse |
| poll_i | input | 1 | Periodic poll pulse |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request completed; read data valid |
| mem_rdata_i | input | 32 | Read data |
| out_valid_o | output | 1 | Frame byte valid |
| out_data_o | output | 8 | Frame byte |
| out_last_o | output | 1 | Final byte of frame |
| out_ready_i | input | 1 | Sink accepts byte / sink ready |
| tx_int_o | output | 1 | One-cycle pulse per completed frame |
| underflow_o | output | 1 | One-cycle pulse on an abandoned chain |

## Verification
The assertions assume that ring_base_i, ring_log2_i and style_i only change while the engine is idle, and never shrink the ring below the current position. They also assume that the memory answers each request with exactly one acknowledge and that host software does not rewrite descriptors during a pass. The stimulus meets these assumptions. It resets the engine before each scenario and sets the ring geometry before the first pulse. It rewrites descriptors only after waiting out a pass. Its memory model acknowledges each request once, one cycle after the request appears.

// File: rtl/tx_gather_pkg.sv
package tx_gather_pkg;
  localparam int OWN_B = 31;
  localparam int STP_B = 25;
  localparam int ENP_B = 24;
  localparam int LEN_W = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_TRY, S_PS_RD, S_PS_CHK, S_D_STAT, S_D_ADDR,
    S_D_CHK, S_D_WORD, S_D_BYTE, S_D_REL, S_D_NEXT, S_F_REL
  } gst_e;

  // length field is stored negated
  function automatic logic [LEN_W-1:0] buf_len(input logic [31:0] stat);
    logic [LEN_W-1:0] f;
    f = stat[LEN_W-1:0];
    return ~f + LEN_W'(1);
  endfunction
endpackage

// File: rtl/tx_ring_step.sv
module tx_ring_step #(
  parameter int IDX_W = 9
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W:0]   len_i,
  output logic [IDX_W-1:0] nxt_o
);
  logic [IDX_W:0] inc;
  assign inc   = {1'b0, idx_i} + (IDX_W+1)'(1);
  assign nxt_o = (inc >= len_i) ? '0 : inc[IDX_W-1:0];
endmodule

// File: rtl/tx_len_sat.sv
module tx_len_sat #(
  parameter int TOT_W = 12,
  parameter int ADD_W = 12,
  parameter int MAX   = 2048
) (
  input  logic [TOT_W-1:0] acc_i,
  input  logic [ADD_W-1:0] add_i,
  output logic [TOT_W-1:0] sum_o
);
  localparam int SUM_W = ((TOT_W > ADD_W) ? TOT_W : ADD_W) + 1;
  logic [SUM_W-1:0] s;
  assign s     = SUM_W'(acc_i) + SUM_W'(add_i);
  assign sum_o = (s > SUM_W'(MAX)) ? TOT_W'(MAX) : s[TOT_W-1:0];
endmodule

// File: rtl/tx_byte_lane.sv
module tx_byte_lane (
  input  logic [31:0] word_i,
  input  logic [1:0]  sel_i,
  output logic [7:0]  byte_o
);
  assign byte_o = word_i[{sel_i, 3'b000} +: 8];
endmodule

// File: rtl/tx_ring_gather.sv
module tx_ring_gather
  import tx_gather_pkg::*;
#(
  parameter int MAX_RING_LOG2 = 9,
  parameter int PASS_FRAMES   = 16,
  parameter int MAX_FRAME     = 2048
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ring_base_i,
  input  logic [3:0]  ring_log2_i,
  input  logic        style_i,
  input  logic        tx_on_i,
  input  logic        demand_i,
  input  logic        poll_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_ack_i,
  input  logic [31:0] mem_rdata_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_last_o,
  input  logic        out_ready_i,
  output logic        tx_int_o,
  output logic        underflow_o
);
  localparam int IDX_W = MAX_RING_LOG2;
  localparam int TOT_W = $clog2(MAX_FRAME + 1);
  localparam int FRM_W = $clog2(PASS_FRAMES + 1);
  localparam logic [31:0] CLR_OWN = ~(32'd1 << OWN_B);

  gst_e             state_q;
  logic [IDX_W-1:0] pos_q, scan_q, first_q, pos_nxt, scan_nxt;
  logic [IDX_W:0]   steps_q, steps_inc, ring_len;
  logic [FRM_W-1:0] frames_q;
  logic [TOT_W-1:0] tot_q, sent_q, tot_sum;
  logic [TOT_W:0]   sent_inc;
  logic [LEN_W-1:0] rem_q;
  logic [31:0]      baddr_q, word_q, stat_q, first_stat_q;
  logic [31:0]      pos_da, scan_da, first_da;
  logic [3:0]       eff_log2;
  logic             last_byte;
  gst_e             rel_st;

  assign eff_log2  = (ring_log2_i > 4'(MAX_RING_LOG2)) ? 4'(MAX_RING_LOG2) : ring_log2_i;
  assign ring_len  = (IDX_W+1)'(1) << eff_log2;
  assign steps_inc = steps_q + (IDX_W+1)'(1);
  assign sent_inc  = {1'b0, sent_q} + (TOT_W+1)'(1);
  assign last_byte = (sent_inc == {1'b0, tot_q});
  assign rel_st    = stat_q[STP_B] ? S_D_NEXT : S_D_REL;

  assign pos_da   = ring_base_i + 32'({pos_q, 4'b0000});
  assign scan_da  = ring_base_i + 32'({scan_q, 4'b0000});
  assign first_da = ring_base_i + 32'({first_q, 4'b0000});

  tx_ring_step #(.IDX_W(IDX_W)) u_pos_step  (.idx_i(pos_q),  .len_i(ring_len), .nxt_o(pos_nxt));
  tx_ring_step #(.IDX_W(IDX_W)) u_scan_step (.idx_i(scan_q), .len_i(ring_len), .nxt_o(scan_nxt));

  tx_len_sat #(.TOT_W(TOT_W), .ADD_W(LEN_W), .MAX(MAX_FRAME)) u_len_sat (
    .acc_i(tot_q), .add_i(buf_len(stat_q)), .sum_o(tot_sum)
  );

  tx_byte_lane u_lane (.word_i(word_q), .sel_i(baddr_q[1:0]), .byte_o(out_data_o));

  assign out_valid_o = (state_q == S_D_BYTE);
  assign out_last_o  = out_valid_o && last_byte;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = pos_da + 32'd4;
    mem_wdata_o = stat_q & CLR_OWN;
    unique case (state_q)
      S_PS_RD:  begin mem_req_o = 1'b1; mem_addr_o = scan_da + 32'd4; end
      S_D_STAT: mem_req_o = 1'b1;
      S_D_ADDR: begin mem_req_o = 1'b1; mem_addr_o = pos_da + (style_i ? 32'd8 : 32'd0); end
      S_D_WORD: begin mem_req_o = 1'b1; mem_addr_o = {baddr_q[31:2], 2'b00}; end
      S_D_REL:  begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      S_F_REL: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = first_da + 32'd4;
        mem_wdata_o = first_stat_q & CLR_OWN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      pos_q        <= '0;
      scan_q       <= '0;
      first_q      <= '0;
      steps_q      <= '0;
      frames_q     <= '0;
      tot_q        <= '0;
      sent_q       <= '0;
      rem_q        <= '0;
      baddr_q      <= '0;
      word_q       <= '0;
      stat_q       <= '0;
      first_stat_q <= '0;
      tx_int_o     <= 1'b0;
      underflow_o  <= 1'b0;
    end else begin
      tx_int_o    <= 1'b0;
      underflow_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (demand_i || poll_i) begin
          frames_q <= '0;
          state_q  <= S_TRY;
        end
        S_TRY: begin
          if (frames_q == FRM_W'(PASS_FRAMES) || ring_base_i == '0 || !tx_on_i || !out_ready_i)
            state_q <= S_IDLE;
          else begin
            first_q <= pos_q;
            scan_q  <= pos_q;
            steps_q <= '0;
            tot_q   <= '0;
            state_q <= S_PS_RD;
          end
        end
        // ownership pre-scan: no side effects until the chain is complete
        S_PS_RD: if (mem_ack_i) begin
          stat_q  <= mem_rdata_i;
          state_q <= S_PS_CHK;
        end
        S_PS_CHK: begin
          if (!stat_q[OWN_B]) begin
            underflow_o <= (steps_q != '0);
            state_q     <= S_IDLE;
          end else begin
            if (steps_q == '0) first_stat_q <= stat_q;
            tot_q   <= tot_sum;
            steps_q <= steps_inc;
            if (stat_q[ENP_B]) begin
              sent_q  <= '0;
              state_q <= S_D_STAT;
            end else if (steps_inc == ring_len) begin
              underflow_o <= 1'b1;
              state_q     <= S_IDLE;
            end else begin
              scan_q  <= scan_nxt;
              state_q <= S_PS_RD;
            end
          end
        end
        S_D_STAT: if (mem_ack_i) begin
          stat_q  <= mem_rdata_i;
          state_q <= S_D_ADDR;
        end
        S_D_ADDR: if (mem_ack_i) begin
          baddr_q <= mem_rdata_i;
          rem_q   <= buf_len(stat_q);
          state_q <= S_D_CHK;
        end
        S_D_CHK: state_q <= (rem_q == '0 || sent_q == tot_q) ? rel_st : S_D_WORD;
        S_D_WORD: if (mem_ack_i) begin
          word_q  <= mem_rdata_i;
          state_q <= S_D_BYTE;
        end
        S_D_BYTE: if (out_ready_i) begin
          sent_q  <= sent_q + TOT_W'(1);
          rem_q   <= rem_q - LEN_W'(1);
          baddr_q <= baddr_q + 32'd1;
          if (rem_q == LEN_W'(1) || last_byte) state_q <= rel_st;
          else if (baddr_q[1:0] == 2'b11)      state_q <= S_D_WORD;
        end
        S_D_REL: if (mem_ack_i) state_q <= S_D_NEXT;
        S_D_NEXT: begin
          pos_q   <= pos_nxt;
          state_q <= stat_q[ENP_B] ? S_F_REL : S_D_STAT;
        end
        S_F_REL: if (mem_ack_i) begin
          tx_int_o <= 1'b1;
          frames_q <= frames_q + FRM_W'(1);
          state_q  <= S_TRY;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R1
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R3
  AST_WR_CLEARS_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[OWN_B]); // R4
  AST_INT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_int_o |=> !tx_int_o); // R5
  AST_UFL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> !underflow_o && !out_valid_o); // R6
  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, pos_q} < ring_len); // R7
  AST_FRAMES_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frames_q <= FRM_W'(PASS_FRAMES)); // R8
  AST_SENT_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> sent_q < tot_q); // R9
endmodule

// File: tb/tx_ring_gather_tb_top.sv
module tx_ring_gather_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] ring_base = BASE;
  logic [3:0]  ring_log2 = 4'd3;
  logic        sty = 1'b0, tx_on = 1'b1, demand = 1'b0, poll = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        out_valid, out_last, out_ready = 1'b1, tx_int, underflow;
  logic [7:0]  out_data;

  logic [31:0] mem [0:2047];
  logic [8:0]  got_q[$], exp_q[$];
  int vectors = 0, fails = 0, int_cnt = 0, ufl_cnt = 0, cyc = 0;
  bit bp_en = 0, force_nr = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_ring_gather dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ring_base_i(ring_base), .ring_log2_i(ring_log2),
    .style_i(sty), .tx_on_i(tx_on), .demand_i(demand), .poll_i(poll),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .out_ready_i(out_ready), .tx_int_o(tx_int), .underflow_o(underflow)
  );

  // memory model: one acknowledge per request, one cycle later
  always @(posedge clk) begin
    if (mem_req && !mem_ack && mem_we) mem[mem_addr[12:2]] = mem_wdata;
    mem_rdata <= mem[mem_addr[12:2]];
    mem_ack   <= mem_req && !mem_ack;
  end

  // monitor and sink, away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && out_valid && out_ready) got_q.push_back({out_last, out_data});
    if (rst_n && tx_int) int_cnt <= int_cnt + 1;
    if (rst_n && underflow) ufl_cnt <= ufl_cnt + 1;
    out_ready <= force_nr ? 1'b0 : !(bp_en && got_q.size() > 0 && cyc[0]);
  end

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] st(bit own, bit stp, bit enp, int len);
    logic [11:0] f;
    f = 12'(-len);
    return {own, 5'b0, stp, enp, 12'h000, f};
  endfunction

  function automatic logic [31:0] stat_of(int idx);
    int a = BASE + idx * 16 + 4;
    return mem[a >> 2];
  endfunction

  task automatic put_desc(int idx, logic [31:0] status, int buf_a);
    int d = BASE + idx * 16;
    mem[(d + 4) >> 2]  = status;
    mem[(d + 12) >> 2] = 32'h5A5A_0000 | idx;
    mem[(d + (sty ? 8 : 0)) >> 2] = buf_a;
    mem[(d + (sty ? 0 : 8)) >> 2] = 32'hC3C3_0000 | idx;
  endtask

  task automatic fill(int a, int n, int seed);
    for (int i = 0; i < n; i++) begin
      int x = a + i;
      mem[(x >> 2) & 2047][(x & 3) * 8 +: 8] = 8'(seed + i * 7);
    end
  endtask

  task automatic add_exp(int a, int n);
    for (int i = 0; i < n; i++) begin
      int x = a + i;
      exp_q.push_back({1'b0, mem[(x >> 2) & 2047][(x & 3) * 8 +: 8]});
    end
    if (exp_q.size() > 0) exp_q[exp_q.size() - 1][8] = 1'b1;
  endtask

  task automatic cmp_stream(string rq);
    int bad = 0;
    chk(got_q.size() == exp_q.size(), rq, "byte count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size() && exp_q.size() > 0) begin
      int first = -1;
      for (int i = 0; i < exp_q.size(); i++)
        if (got_q[i] !== exp_q[i]) begin
          bad++;
          if (first < 0) first = i;
        end
      if (first < 0) first = 0;
      chk(bad == 0, rq, "stream {last,byte}", got_q[first], exp_q[first]);
    end
  endtask

  task automatic kick(bit use_poll);
    @(negedge clk);
    if (use_poll) poll = 1'b1; else demand = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    demand = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(logic [3:0] l2, bit s);
    @(negedge clk);
    rst_n = 1'b0;
    ring_log2 = l2;
    sty = s;
    ring_base = BASE;
    tx_on = 1'b1;
    bp_en = 0;
    force_nr = 0;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    settle(3);
    got_q.delete();
    exp_q.delete();
    int_cnt = 0;
    ufl_cnt = 0;
    rst_n = 1'b1;
    settle(2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    settle(2);
    chk(out_valid == 0, "R3", "reset out_valid", out_valid, 0);
    chk(mem_req == 0, "R1", "reset mem_req", mem_req, 0);
    chk(tx_int == 0 && underflow == 0, "R5", "reset pulses", {tx_int, underflow}, 0);
  endtask

  task automatic t_single;
    restart(4'd3, 1'b0);
    fill(32'h1000, 6, 8'h11);
    put_desc(0, st(1, 1, 1, 6) | 32'h2000_0000, 32'h1000);
    add_exp(32'h1000, 6);
    kick(0);
    settle(200);
    cmp_stream("R1");
    chk(stat_of(0) == (st(0, 1, 1, 6) | 32'h2000_0000), "R5", "first released", stat_of(0), st(0, 1, 1, 6) | 32'h2000_0000);
    chk(int_cnt == 1, "R5", "interrupt count", int_cnt, 1);
  endtask

  task automatic t_chain;
    restart(4'd3, 1'b1);
    bp_en = 1;
    fill(32'h1001, 5, 8'h40);
    fill(32'h1103, 4, 8'h90);
    put_desc(0, st(1, 1, 0, 5), 32'h1001);
    put_desc(1, st(1, 0, 0, 0), 32'h1080);
    put_desc(2, st(1, 0, 1, 4) | 32'h4000_0000, 32'h1103);
    add_exp(32'h1001, 5);
    exp_q[exp_q.size() - 1][8] = 1'b0;
    add_exp(32'h1103, 4);
    kick(0);
    settle(300);
    cmp_stream("R3");
    chk(stat_of(1) == st(0, 0, 0, 0), "R4", "middle released", stat_of(1), st(0, 0, 0, 0));
    chk(stat_of(2) == (st(0, 0, 1, 4) | 32'h4000_0000), "R4", "end released, bits kept", stat_of(2), st(0, 0, 1, 4) | 32'h4000_0000);
    chk(stat_of(0) == st(0, 1, 0, 5), "R5", "first released", stat_of(0), st(0, 1, 0, 5));
    chk(int_cnt == 1, "R5", "one interrupt per chained frame", int_cnt, 1);
  endtask

  task automatic t_not_owned;
    restart(4'd3, 1'b0);
    fill(32'h1200, 4, 8'h21);
    put_desc(0, st(0, 1, 1, 4), 32'h1200);
    kick(0);
    settle(100);
    chk(got_q.size() == 0 && int_cnt == 0 && ufl_cnt == 0, "R2", "unowned first: no activity", got_q.size() + int_cnt + ufl_cnt, 0);
    chk(stat_of(0) == st(0, 1, 1, 4), "R2", "unowned status untouched", stat_of(0), st(0, 1, 1, 4));
    put_desc(0, st(1, 1, 1, 4), 32'h1200);
    add_exp(32'h1200, 4);
    kick(1);
    settle(200);
    cmp_stream("R7");
    chk(int_cnt == 1, "R8", "poll starts pass", int_cnt, 1);
  endtask

  task automatic t_underflow;
    restart(4'd3, 1'b0);
    fill(32'h1300, 3, 8'h33);
    fill(32'h1340, 2, 8'h77);
    put_desc(0, st(1, 1, 0, 3), 32'h1300);
    put_desc(1, st(0, 0, 1, 2), 32'h1340);
    kick(0);
    settle(100);
    chk(ufl_cnt == 1, "R6", "underflow pulse count", ufl_cnt, 1);
    chk(got_q.size() == 0 && int_cnt == 0, "R6", "no bytes, no interrupt", got_q.size() + int_cnt, 0);
    chk(stat_of(0) == st(1, 1, 0, 3), "R6", "first still owned", stat_of(0), st(1, 1, 0, 3));
    put_desc(1, st(1, 0, 1, 2), 32'h1340);
    add_exp(32'h1300, 3);
    exp_q[exp_q.size() - 1][8] = 1'b0;
    add_exp(32'h1340, 2);
    kick(1);
    settle(200);
    cmp_stream("R6");
    chk(stat_of(0) == st(0, 1, 0, 3) && stat_of(1) == st(0, 0, 1, 2), "R6", "retry releases both", stat_of(1), st(0, 0, 1, 2));
  endtask

  task automatic t_gating;
    restart(4'd3, 1'b0);
    fill(32'h1400, 5, 8'h55);
    put_desc(0, st(1, 1, 1, 5), 32'h1400);
    tx_on = 1'b0;
    kick(0);
    settle(60);
    chk(got_q.size() == 0 && int_cnt == 0, "R2", "tx_on low blocks", got_q.size() + int_cnt, 0);
    tx_on = 1'b1;
    force_nr = 1;
    settle(2);
    kick(0);
    settle(60);
    chk(got_q.size() == 0 && int_cnt == 0, "R2", "sink not ready blocks", got_q.size() + int_cnt, 0);
    force_nr = 0;
    ring_base = 32'h0;
    settle(2);
    kick(0);
    settle(60);
    chk(got_q.size() == 0 && int_cnt == 0, "R2", "zero base blocks", got_q.size() + int_cnt, 0);
    chk(stat_of(0) == st(1, 1, 1, 5), "R2", "still owned", stat_of(0), st(1, 1, 1, 5));
    ring_base = BASE;
    add_exp(32'h1400, 5);
    kick(1);
    settle(200);
    cmp_stream("R2");
  endtask

  task automatic t_burst;
    restart(4'd5, 1'b0);
    for (int i = 0; i < 20; i++) begin
      fill(32'h1000 + i * 16, 3, i);
      put_desc(i, st(1, 1, 1, 3), 32'h1000 + i * 16);
    end
    for (int i = 0; i < 16; i++) add_exp(32'h1000 + i * 16, 3);
    kick(0);
    settle(1500);
    chk(int_cnt == 16, "R8", "frames in one pass", int_cnt, 16);
    cmp_stream("R8");
    chk(stat_of(16) == st(1, 1, 1, 3), "R8", "17th frame untouched", stat_of(16), st(1, 1, 1, 3));
    kick(1);
    settle(600);
    chk(int_cnt == 20, "R8", "remaining frames after poll", int_cnt, 20);
    chk(stat_of(19) == st(0, 1, 1, 3), "R7", "last frame released", stat_of(19), st(0, 1, 1, 3));
  endtask

  task automatic t_wrap;
    restart(4'd2, 1'b0);
    for (int i = 0; i < 3; i++) begin
      fill(32'h1000 + i * 16, 2, 8'h60 + i);
      put_desc(i, st(1, 1, 1, 2), 32'h1000 + i * 16);
      add_exp(32'h1000 + i * 16, 2);
    end
    kick(0);
    settle(300);
    chk(int_cnt == 3, "R7", "three frames", int_cnt, 3);
    fill(32'h1100, 3, 8'hA0);
    fill(32'h1200, 2, 8'hB0);
    put_desc(3, st(1, 1, 0, 3), 32'h1100);
    put_desc(0, st(1, 0, 1, 2), 32'h1200);
    add_exp(32'h1100, 3);
    exp_q[exp_q.size() - 1][8] = 1'b0;
    add_exp(32'h1200, 2);
    kick(1);
    settle(300);
    cmp_stream("R7");
    chk(stat_of(0) == st(0, 0, 1, 2) && stat_of(3) == st(0, 1, 0, 3), "R7", "wrapped chain released", stat_of(0), st(0, 0, 1, 2));
  endtask

  task automatic t_trunc;
    restart(4'd2, 1'b0);
    fill(32'h0800, 1000, 8'h01);
    fill(32'h0C00, 1000, 8'h02);
    fill(32'h1800, 100, 8'h03);
    put_desc(0, st(1, 1, 0, 1000), 32'h0800);
    put_desc(1, st(1, 0, 0, 1000), 32'h0C00);
    put_desc(2, st(1, 0, 1, 100), 32'h1800);
    add_exp(32'h0800, 1000);
    exp_q[exp_q.size() - 1][8] = 1'b0;
    add_exp(32'h0C00, 1000);
    exp_q[exp_q.size() - 1][8] = 1'b0;
    add_exp(32'h1800, 48);
    kick(0);
    settle(5000);
    cmp_stream("R9");
    chk(stat_of(2) == st(0, 0, 1, 100) && stat_of(0) == st(0, 1, 0, 1000), "R9", "all released", stat_of(2), st(0, 0, 1, 100));
    chk(int_cnt == 1, "R9", "interrupt", int_cnt, 1);
  endtask

  task automatic t_zero;
    restart(4'd3, 1'b0);
    put_desc(0, st(1, 1, 1, 0), 32'h1000);
    kick(0);
    settle(100);
    chk(got_q.size() == 0, "R10", "no bytes", got_q.size(), 0);
    chk(int_cnt == 1, "R10", "interrupt", int_cnt, 1);
    chk(stat_of(0) == st(0, 1, 1, 0), "R10", "released", stat_of(0), st(0, 1, 1, 0));
  endtask

  initial begin
    t_reset();
    t_single();
    t_chain();
    t_not_owned();
    t_underflow();
    t_gating();
    t_burst();
    t_wrap();
    t_trunc();
    t_zero();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule